// File: doc/BRIEF.md
# Real-Time Clock Seconds Timebase with Drift Compensation

The block divides an oscillator clock down to one-second steps and keeps a 32-bit running seconds count. A 15-bit prescaler counts clock cycles. When it completes a second, the seconds counter advances by one and a single-cycle tick is raised. The clock runs either from a 32.768 kHz crystal or from a 1 kHz low-power oscillator. A select input tells the block which source is present, and so how many cycles make a nominal second.

Crystal drift is corrected by a compensation word. It holds a signed cycle adjustment and an interval in seconds. Once per interval, the first second of the interval is shortened or lengthened by the adjustment, and the other seconds of the interval run at nominal length. A word written through the write port is held back: it becomes active at a seconds increment, and only when the running interval has finished. On the slow source the adjustment is scaled down by 32, which keeps the correction to a few cycles.

Top module: `rtc_drift_timebase`

## Requirements
- R1: While `rst_ni` is low and after its release, `seconds_o` reads 0 and `sec_tick_o` is low until the first second has completed.
- R2: With a compensation word of zero, every second lasts 32768 clock cycles when `src_slow_i`=0 and 1000 clock cycles when `src_slow_i`=1. Writing zero disables compensation entirely.
- R3: On each completed second, `seconds_o` increases by exactly one and `sec_tick_o` is high for one cycle. That cycle is the first one in which the new count is visible, and the count changes at no other time.
- R4: The compensation word is `comp_wdata_i[7:0]` = adjustment A (two's complement) and `comp_wdata_i[15:8]` = interval N. On the fast source, a compensated second lasts 32768 − A cycles. A positive A shortens the second and a negative A lengthens it, from −128 to +127.
- R5: On the slow source, the effective adjustment is A arithmetically shifted right by 5 bits, so it ranges from −4 to +3. A compensated second lasts 1000 − (A>>>5) cycles.
- R6: An interval of N groups the seconds into runs of N+1. Only the first second of each run is compensated, and the remaining N seconds have nominal length.
- R7: A written word becomes active only at a seconds increment at which the running interval has fully elapsed. Until then the previous word keeps governing the seconds. The second that begins at that increment is the first compensated one under the new word.
- R8: While `cnt_en_i` is low, the prescaler and the seconds count hold and no tick is produced. Each disabled cycle lengthens the current second by one cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock (32.768 kHz or 1 kHz source) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter enable; prescaler and seconds advance only while high |
| src_slow_i | input | 1 | Clock source select: 0 = 32.768 kHz, 1 = 1 kHz |
| comp_we_i | input | 1 | Write strobe for the compensation word |
| comp_wdata_i | input | 16 | Compensation word: [15:8] interval, [7:0] signed adjustment |
| sec_tick_o | output | 1 | One-cycle pulse per completed second |
| seconds_o | output | 32 | Seconds count |

## Verification
The tick and the new count appear together, one clock after the clock edge on which the prescaler finishes its second. The distance between two ticks therefore equals that second's length plus any disabled cycles. A write reaches the counts no earlier than the second after the next tick, because the word waits for an increment at which the interval has expired. The bench drives and samples on the falling edge. It updates its own schedule model at each observed tick before it issues new writes, so each measured tick-to-tick distance is compared with the length predicted for exactly that second.

// File: rtl/rtc_tmb_pkg.sv
package rtc_tmb_pkg;
  localparam int unsigned CMP_VAL_W = 8;
  localparam int unsigned CMP_IVL_W = 8;
  localparam int unsigned CMP_W     = CMP_VAL_W + CMP_IVL_W;

  typedef struct packed {
    logic [CMP_IVL_W-1:0] ivl;
    logic [CMP_VAL_W-1:0] val;
  } comp_cfg_t;
endpackage

// File: rtl/rtc_comp_sched.sv
module rtc_comp_sched
  import rtc_tmb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  comp_cfg_t            wdata_i,
  input  logic                 sec_inc_i,
  output logic [CMP_VAL_W-1:0] act_val_o,
  output logic                 first_o
);
  comp_cfg_t            pend_q;
  logic [CMP_IVL_W-1:0] ivl_q;
  logic [CMP_VAL_W-1:0] act_q;
  logic                 first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      ivl_q   <= '0;
      act_q   <= '0;
      first_q <= 1'b1;
    end else begin
      if (we_i) pend_q <= wdata_i;
      if (sec_inc_i) begin
        if (ivl_q == '0) begin
          // interval expired: adopt pending word, new run starts compensated
          act_q   <= pend_q.val;
          ivl_q   <= pend_q.ivl;
          first_q <= 1'b1;
        end else begin
          ivl_q   <= ivl_q - 1'b1;
          first_q <= 1'b0;
        end
      end
    end
  end

  assign act_val_o = act_q;
  assign first_o   = first_q;
endmodule

// File: rtl/rtc_adj_calc.sv
module rtc_adj_calc
  import rtc_tmb_pkg::*;
#(
  parameter int unsigned PRESC_W    = 15,
  parameter int unsigned FAST_CYC   = 32768,
  parameter int unsigned SLOW_CYC   = 1000,
  parameter int unsigned SLOW_SHIFT = 5
) (
  input  logic                 slow_i,
  input  logic                 first_i,
  input  logic [CMP_VAL_W-1:0] val_i,
  output logic [PRESC_W-1:0]   term_o,
  output logic [CMP_VAL_W-1:0] stall_o
);
  localparam int unsigned NOM_W = PRESC_W + 1;
  localparam logic [NOM_W-1:0] FAST_N = NOM_W'(FAST_CYC);
  localparam logic [NOM_W-1:0] SLOW_N = NOM_W'(SLOW_CYC);

  logic signed [CMP_VAL_W-1:0] val_s;
  logic signed [CMP_VAL_W-1:0] eff;
  logic signed [CMP_VAL_W-1:0] neg_eff;
  logic [NOM_W-1:0]            nom;
  logic [NOM_W-1:0]            shorten;

  always_comb begin
    val_s = signed'(val_i);
    eff   = '0;
    if (first_i) eff = slow_i ? (val_s >>> SLOW_SHIFT) : val_s;
    neg_eff = -eff;
    nom     = slow_i ? SLOW_N : FAST_N;
    shorten = eff[CMP_VAL_W-1] ? '0 : NOM_W'(unsigned'(eff));
    term_o  = PRESC_W'(nom - shorten - NOM_W'(1));
    // negative adjustment: hold the prescaler at its last count
    stall_o = eff[CMP_VAL_W-1] ? unsigned'(neg_eff) : '0;
  end
endmodule

// File: rtl/rtc_presc.sv
module rtc_presc #(
  parameter int unsigned PRESC_W = 15,
  parameter int unsigned STALL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] term_i,
  input  logic [STALL_W-1:0] stall_i,
  output logic               wrap_o,
  output logic [PRESC_W-1:0] cnt_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic [STALL_W-1:0] stall_q;
  logic               at_end;
  logic               stretch_done;

  assign at_end       = cnt_q >= term_i;
  assign stretch_done = stall_q >= stall_i;
  assign wrap_o       = en_i & at_end & stretch_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stall_q <= '0;
    end else if (en_i) begin
      if (at_end) begin
        if (stretch_done) begin
          cnt_q   <= '0;
          stall_q <= '0;
        end else begin
          stall_q <= stall_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_sec_cnt.sv
module rtc_sec_cnt #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic             tick_o,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= inc_i;
      if (inc_i) sec_q <= sec_q + 1'b1;
    end
  end

  assign sec_o  = sec_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/rtc_drift_timebase.sv
module rtc_drift_timebase
  import rtc_tmb_pkg::*;
#(
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned PRESC_W    = 15,
  parameter int unsigned FAST_CYC   = 32768,
  parameter int unsigned SLOW_CYC   = 1000,
  parameter int unsigned SLOW_SHIFT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             src_slow_i,
  input  logic             comp_we_i,
  input  logic [CMP_W-1:0] comp_wdata_i,
  output logic             sec_tick_o,
  output logic [SEC_W-1:0] seconds_o
);
  logic                 sec_inc;
  logic [CMP_VAL_W-1:0] act_val;
  logic                 act_first;
  logic [PRESC_W-1:0]   term;
  logic [CMP_VAL_W-1:0] stall;
  logic [PRESC_W-1:0]   presc_cnt;

  rtc_comp_sched u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (comp_we_i),
    .wdata_i   (comp_cfg_t'(comp_wdata_i)),
    .sec_inc_i (sec_inc),
    .act_val_o (act_val),
    .first_o   (act_first)
  );

  rtc_adj_calc #(
    .PRESC_W    (PRESC_W),
    .FAST_CYC   (FAST_CYC),
    .SLOW_CYC   (SLOW_CYC),
    .SLOW_SHIFT (SLOW_SHIFT)
  ) u_adj (
    .slow_i  (src_slow_i),
    .first_i (act_first),
    .val_i   (act_val),
    .term_o  (term),
    .stall_o (stall)
  );

  rtc_presc #(
    .PRESC_W (PRESC_W),
    .STALL_W (CMP_VAL_W)
  ) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cnt_en_i),
    .term_i  (term),
    .stall_i (stall),
    .wrap_o  (sec_inc),
    .cnt_o   (presc_cnt)
  );

  rtc_sec_cnt #(
    .SEC_W (SEC_W)
  ) u_sec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sec_inc),
    .tick_o (sec_tick_o),
    .sec_o  (seconds_o)
  );
endmodule

// File: rtl/rtc_drift_timebase_chk.sv
module rtc_drift_timebase_chk #(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned PRESC_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cnt_en_i,
  input logic               sec_tick_o,
  input logic [SEC_W-1:0]   seconds_o,
  input logic [PRESC_W-1:0] presc_i
);
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o); // R3
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> seconds_o == SEC_W'($past(seconds_o) + 1'b1)); // R3
  AST_SEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_o |-> $stable(seconds_o)); // R3
  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> presc_i == '0); // R3
  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> (!sec_tick_o && $stable(seconds_o))); // R8
  AST_OFF_PRESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(presc_i)); // R8
endmodule

bind rtc_drift_timebase rtc_drift_timebase_chk #(
  .SEC_W   (SEC_W),
  .PRESC_W (PRESC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .sec_tick_o (sec_tick_o),
  .seconds_o  (seconds_o),
  .presc_i    (presc_cnt)
);

// File: tb/rtc_drift_timebase_tb.sv
module rtc_drift_timebase_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  RAND_TICKS = 45;
  localparam int  TOTAL_TICKS = 18 + RAND_TICKS;
  localparam int  PAUSE_LEN = 40;
  localparam int  WD_CYC = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cnt_en_i;
  logic        src_slow_i;
  logic        comp_we_i;
  logic [15:0] comp_wdata_i;
  logic        sec_tick_o;
  logic [31:0] seconds_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_drift_timebase u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_en_i     (cnt_en_i),
    .src_slow_i   (src_slow_i),
    .comp_we_i    (comp_we_i),
    .comp_wdata_i (comp_wdata_i),
    .sec_tick_o   (sec_tick_o),
    .seconds_o    (seconds_o)
  );

  int checks = 0;
  int errors = 0;

  // bench-side compensation schedule
  logic [7:0] m_pend_val = '0, m_act_val = '0;
  int         m_pend_ivl = 0, m_ivl = 0;
  bit         m_first = 1'b1;
  bit         m_slow = 1'b1;
  int         m_sec = 0;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_period(bit slow, bit first, logic [7:0] val);
    int v;
    int eff;
    v   = int'($signed(val));
    eff = 0;
    if (first) eff = slow ? (v >>> 5) : v;
    return (slow ? 1000 : 32768) - eff;
  endfunction

  task automatic wr(logic [7:0] val, int ivl);
    comp_we_i    = 1'b1;
    comp_wdata_i = {8'(ivl), val};
    m_pend_val   = val;
    m_pend_ivl   = ivl;
  endtask

  initial begin
    int    cyc;
    int    last_cyc;
    int    ticks;
    int    extra;
    int    pause_at;
    bit    have_last;
    string tag_sec;
    void'($urandom(32'd4021));
    cyc = 0; last_cyc = 0; ticks = 0; extra = 0; pause_at = 0;
    have_last = 1'b0; tag_sec = "R2";
    rst_ni = 1'b0; cnt_en_i = 1'b0; src_slow_i = 1'b1;
    comp_we_i = 1'b0; comp_wdata_i = '0;
    repeat (5) @(negedge clk_i);
    chk("R1", int'(seconds_o), 0, "seconds in reset");
    chk("R1", int'(sec_tick_o), 0, "tick in reset");
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R8", int'(seconds_o), 0, "seconds while disabled");
    chk("R1", int'(sec_tick_o), 0, "tick after reset release");
    cnt_en_i = 1'b1;

    while (ticks < TOTAL_TICKS) begin
      @(negedge clk_i);
      cyc++;
      comp_we_i = 1'b0;
      if (cyc > WD_CYC) begin
        errors++;
        $display("FAIL watchdog expired at tick %0d", ticks);
        break;
      end
      if (pause_at > 0 && cyc == pause_at) cnt_en_i = 1'b0;
      if (pause_at > 0 && cyc > pause_at && cyc <= pause_at + PAUSE_LEN) begin
        chk("R8", int'(sec_tick_o), 0, "tick while disabled");
        chk("R8", int'(seconds_o), m_sec, "seconds while disabled");
        if (cyc == pause_at + PAUSE_LEN) begin
          cnt_en_i = 1'b1;
          extra   += PAUSE_LEN;
          pause_at = 0;
        end
      end
      if (have_last && cyc == last_cyc + 1)
        chk("R3", int'(sec_tick_o), 0, "tick width");
      if (sec_tick_o) begin
        if (have_last)
          chk(tag_sec, cyc - last_cyc, exp_period(m_slow, m_first, m_act_val) + extra,
              "second length");
        m_sec++;
        if (m_ivl == 0) begin
          m_act_val = m_pend_val;
          m_ivl     = m_pend_ivl;
          m_first   = 1'b1;
        end else begin
          m_ivl--;
          m_first = 1'b0;
        end
        chk("R3", int'(seconds_o), m_sec, "seconds count");
        have_last = 1'b1;
        last_cyc  = cyc;
        extra     = 0;
        ticks++;
        case (ticks)
          3:  begin wr(8'd100, 0); tag_sec = "R5"; end
          6:  begin wr(8'h80, 2); tag_sec = "R6"; end
          8:  begin wr(8'd64, 0); tag_sec = "R7"; end
          12: begin wr(8'd0, 0); tag_sec = "R2"; end
          14: begin src_slow_i = 1'b0; m_slow = 1'b0; wr(8'd127, 0); tag_sec = "R2"; end
          15: begin wr(8'h80, 0); tag_sec = "R4"; end
          16: tag_sec = "R4";
          17: begin src_slow_i = 1'b1; m_slow = 1'b1; tag_sec = "R5"; end
          default: begin
            if (ticks > 17) begin
              tag_sec = "R7";
              if ($urandom % 3 == 0) wr(8'($urandom), int'($urandom % 4));
              if (ticks % 5 == 0) pause_at = cyc + 300;
            end
          end
        endcase
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule